// File: doc/BRIEF.md
# Runtime-configurable serial transmitter

This block turns parallel data words into asynchronous serial frames on one output line. Each frame is a low start bit, then 5 to 8 data bits in either bit order, then an optional even or odd parity bit, then a high stop period of one, one and a half or two bit times. The line rests high between frames. The frame shape and the bit rate are set through configuration inputs. The block samples them together with the data word at the moment the word is accepted, so a frame already on the line never changes shape.

Bit timing is built from half-bit ticks. A programmable divisor gives the number of system clocks in one half bit. A data bit lasts two half-bit ticks, and the one-and-a-half stop period is exactly three. With a 16-bit divisor and a 100 MHz system clock, the rates from 2400 up to 115200 bit/s are all in reach.

Words enter through a valid/ready handshake. While a frame is being sent, ready is low and busy is high.

Top module: `serial_tx_core`

## Requirements
- R1: After reset, and whenever no frame is being sent, `txd` is 1, `in_ready` is 1 and `busy` is 0.
- R2: A word is accepted on a rising clock edge where `in_valid` and `in_ready` are both 1. From the next cycle until the frame ends, `in_ready` is 0 and `busy` is 1.
- R3: The frame starts in the cycle right after the accepting edge, with `txd` low for one bit time (two half-bit ticks).
- R4: The data bits follow the start bit, one bit time each, with 0 sent as low and 1 as high. `len_code` values 0, 1, 2 and 3 select 5, 6, 7 and 8 bits, taken from the low bits of `in_data`.
- R5: With `msb_first` at 0, bit 0 of `in_data` is sent first. With `msb_first` at 1, the highest active bit (bit N-1 for N data bits) is sent first.
- R6: `par_cfg` values: 0 means no parity, 1 means even, 2 means odd, and 3 acts as no parity. When parity is on, one parity bit follows the last data bit. With even parity, the active data bits plus the parity bit hold an even number of ones; odd parity is the inverse. Bits above the active length are never counted.
- R7: The stop period holds `txd` high. `stop_cfg` values 0, 1 and 2 select 2, 3 and 4 half-bit ticks, and 3 acts as 4.
- R8: One half-bit tick lasts `half_div` clocks, and a value of 0 acts as 1.
- R9: Data and every configuration input (including `half_div`) are sampled only at the accepting edge. Changing them during a frame does not change that frame.
- R10: `in_ready` returns to 1 in the cycle after the last stop tick. `in_valid` held high while `busy` is 1 is not accepted; the word waiting on the inputs is taken at the next edge where `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| half_div | input | DIV_W | System clocks per half-bit tick (0 acts as 1) |
| len_code | input | 2 | Data length select: 5 plus this value |
| par_cfg | input | 2 | Parity select: 0 none, 1 even, 2 odd, 3 none |
| stop_cfg | input | 2 | Stop select: 0 one bit, 1 one and a half, 2 or 3 two bits |
| msb_first | input | 1 | 1 sends the highest active data bit first |
| in_data | input | 8 | Data word to send |
| in_valid | input | 1 | Word on the inputs is ready to be taken |
| in_ready | output | 1 | Block can accept a word at this edge |
| busy | output | 1 | A frame is on the line |
| txd | output | 1 | Serial output, idle high |

## Verification
The hardest case to reach from the ports is a frame whose configuration, data and divisor all change while it is still on the line, with `in_valid` kept high the whole time. The stimulus scrambles every input on the cycle right after acceptance, and in some runs it loads the next word at once while the line is still busy. A behavioural model in the bench builds the expected line level for every clock from the values seen at the accepting edge. Any frame that used late values then shows up as a one-cycle miscompare. Random frames with divisors of 0 to 4 cover every length, parity, stop and order code, including the two alias codes and the three-half-tick stop period.

// File: rtl/stx_pkg.sv
package stx_pkg;

    localparam int WORD_MAX = 8;
    localparam int WORD_MIN = 5;
    localparam int LEN_W    = 2;
    localparam int NB_W     = 4;
    localparam int HALF_W   = 5;

    typedef enum logic [1:0] {
        PAR_NONE     = 2'd0,
        PAR_EVEN     = 2'd1,
        PAR_ODD      = 2'd2,
        PAR_ALT_NONE = 2'd3
    } par_e;

    typedef enum logic [1:0] {
        STOP_ONE      = 2'd0,
        STOP_ONE_HALF = 2'd1,
        STOP_TWO      = 2'd2,
        STOP_ALT_TWO  = 2'd3
    } stop_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } phase_e;

    // Frame shape captured at acceptance
    typedef struct packed {
        logic [NB_W-1:0]   nbits;
        logic              par_on;
        logic              par_bit;
        logic [HALF_W-1:0] total;
    } frame_t;

    function automatic logic [NB_W-1:0] word_bits(input logic [LEN_W-1:0] code);
        return NB_W'(code) + NB_W'(WORD_MIN);
    endfunction

    function automatic logic [2:0] stop_len(input stop_e m);
        case (m)
            STOP_ONE:      return 3'd2;
            STOP_ONE_HALF: return 3'd3;
            default:       return 3'd4;
        endcase
    endfunction

    // Places active bits so that index 0 is always sent first
    function automatic logic [WORD_MAX-1:0] order_word(
        input logic [WORD_MAX-1:0] d,
        input logic [NB_W-1:0]     n,
        input logic                msb
    );
        logic [WORD_MAX-1:0] r;
        r = '0;
        for (int i = 0; i < WORD_MAX; i++) begin
            if (i < int'(n)) begin
                r[i] = msb ? d[int'(n) - 1 - i] : d[i];
            end
        end
        return r;
    endfunction

    function automatic logic parity_of(
        input logic [WORD_MAX-1:0] d,
        input logic [NB_W-1:0]     n,
        input logic                odd
    );
        logic acc;
        acc = odd;
        for (int i = 0; i < WORD_MAX; i++) begin
            if (i < int'(n)) begin
                acc = acc ^ d[i];
            end
        end
        return acc;
    endfunction

    function automatic logic [HALF_W-1:0] frame_halves(
        input logic [NB_W-1:0] n,
        input logic            par_on,
        input logic [2:0]      stop_h
    );
        return HALF_W'(2) * (HALF_W'(1) + HALF_W'(n) + HALF_W'(par_on)) + HALF_W'(stop_h);
    endfunction

endpackage

// File: rtl/stx_cfg_latch.sv
module stx_cfg_latch
    import stx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [WORD_MAX-1:0] in_data,
    input  logic [LEN_W-1:0]    len_code,
    input  par_e                par_mode,
    input  stop_e               stop_mode,
    input  logic                msb_first,
    input  logic [DIV_W-1:0]    div_in,
    output frame_t              frm,
    output logic [WORD_MAX-1:0] word_q,
    output logic [DIV_W-1:0]    div_q
);

    frame_t              frm_nxt;
    logic [WORD_MAX-1:0] word_nxt;
    logic                par_on;

    always_comb begin
        par_on           = (par_mode == PAR_EVEN) || (par_mode == PAR_ODD);
        frm_nxt.nbits    = word_bits(len_code);
        frm_nxt.par_on   = par_on;
        frm_nxt.par_bit  = parity_of(in_data, frm_nxt.nbits, par_mode == PAR_ODD);
        frm_nxt.total    = frame_halves(frm_nxt.nbits, par_on, stop_len(stop_mode));
        word_nxt         = order_word(in_data, frm_nxt.nbits, msb_first);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frm    <= '0;
            word_q <= '0;
            div_q  <= '0;
        end else if (load) begin
            frm    <= frm_nxt;
            word_q <= word_nxt;
            div_q  <= div_in;
        end
    end

endmodule

// File: rtl/stx_halftick.sv
module stx_halftick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] eff;

    always_comb begin
        eff  = (div == '0) ? DIV_W'(1) : div;
        tick = run && (cnt == eff - DIV_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

endmodule

// File: rtl/stx_seq.sv
module stx_seq
    import stx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                accept,
    input  logic                tick,
    input  frame_t              frm,
    input  logic [WORD_MAX-1:0] word_q,
    output logic                busy,
    output logic                txd
);

    phase_e            phase;
    logic [HALF_W-1:0] hcnt;
    logic [NB_W-1:0]   idx;
    logic              lvl;
    logic              last_half;

    always_comb begin
        idx       = hcnt[HALF_W-1:1];
        last_half = tick && (hcnt == frm.total - HALF_W'(1));
        if (idx == '0) begin
            lvl = 1'b0;
        end else if (idx <= frm.nbits) begin
            lvl = word_q[3'(idx - NB_W'(1))];
        end else if (frm.par_on && (idx == frm.nbits + NB_W'(1))) begin
            lvl = frm.par_bit;
        end else begin
            lvl = 1'b1;
        end
        busy = (phase == ST_SEND);
        txd  = busy ? lvl : 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= ST_IDLE;
            hcnt  <= '0;
        end else begin
            case (phase)
                ST_IDLE: begin
                    hcnt <= '0;
                    if (accept) phase <= ST_SEND;
                end
                default: begin
                    if (last_half) begin
                        phase <= ST_IDLE;
                        hcnt  <= '0;
                    end else if (tick) begin
                        hcnt <= hcnt + HALF_W'(1);
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/serial_tx_core.sv
module serial_tx_core
    import stx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [DIV_W-1:0]    half_div,
    input  logic [LEN_W-1:0]    len_code,
    input  logic [1:0]          par_cfg,
    input  logic [1:0]          stop_cfg,
    input  logic                msb_first,
    input  logic [WORD_MAX-1:0] in_data,
    input  logic                in_valid,
    output logic                in_ready,
    output logic                busy,
    output logic                txd
);

    frame_t              frm;
    logic [WORD_MAX-1:0] word_q;
    logic [DIV_W-1:0]    div_q;
    logic                accept;
    logic                tick;
    logic                busy_w;

    assign in_ready = !busy_w;
    assign busy     = busy_w;
    assign accept   = in_valid && !busy_w;

    stx_cfg_latch #(.DIV_W(DIV_W)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .in_data   (in_data),
        .len_code  (len_code),
        .par_mode  (par_e'(par_cfg)),
        .stop_mode (stop_e'(stop_cfg)),
        .msb_first (msb_first),
        .div_in    (half_div),
        .frm       (frm),
        .word_q    (word_q),
        .div_q     (div_q)
    );

    stx_halftick #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (busy_w),
        .div  (div_q),
        .tick (tick)
    );

    stx_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .tick   (tick),
        .frm    (frm),
        .word_q (word_q),
        .busy   (busy_w),
        .txd    (txd)
    );

endmodule

// File: rtl/stx_chk.sv
module stx_chk (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic in_ready,
    input logic busy,
    input logic txd
);

    // R1
    idle_line_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> txd);

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> busy);

    // R3
    start_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !txd);

    // R7
    stop_high_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(txd));

    // R10
    ready_return_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(in_ready) |-> ($past(busy) && txd));

endmodule

bind serial_tx_core stx_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .busy     (busy),
    .txd      (txd)
);

// File: tb/sim_serial_tx_core.sv
module sim_serial_tx_core;

    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [DIV_W-1:0] half_div = 16'd2;
    logic [1:0]       len_code = 2'd3;
    logic [1:0]       par_cfg = 2'd0;
    logic [1:0]       stop_cfg = 2'd0;
    logic             msb_first = 1'b0;
    logic [7:0]       in_data = 8'h00;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic             busy;
    logic             txd;

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    bit    rdy_n = 1'b0;
    bit    exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    serial_tx_core #(.DIV_W(DIV_W)) u0 (
        .clk       (clk),
        .rst       (rst),
        .half_div  (half_div),
        .len_code  (len_code),
        .par_cfg   (par_cfg),
        .stop_cfg  (stop_cfg),
        .msb_first (msb_first),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .busy      (busy),
        .txd       (txd)
    );

    task automatic add_level(input bit v, input int halves, input int d, input string t);
        repeat (halves * d) begin
            exp_q.push_back(v);
            tag_q.push_back(t);
        end
    endtask

    // Reference: expected line level for each clock of one frame
    task automatic push_frame(input logic [7:0] dat, input int len, input int par,
                              input int stp, input bit msb, input int div);
        int n;
        int d;
        int ones;
        n = len + 5;
        d = (div == 0) ? 1 : div;
        ones = 0;
        add_level(1'b0, 2, d, "R3 R8 R9");
        for (int i = 0; i < n; i++) begin
            bit b;
            b = msb ? dat[n - 1 - i] : dat[i];
            if (b) ones++;
            add_level(b, 2, d, "R4 R5 R8 R9");
        end
        if (par == 1) add_level(bit'(ones % 2), 2, d, "R6 R9");
        if (par == 2) add_level(bit'((ones + 1) % 2), 2, d, "R6 R9");
        add_level(1'b1, (stp == 0) ? 2 : (stp == 1) ? 3 : 4, d, "R7 R9");
    endtask

    always @(posedge clk) begin
        if (rst) begin
            exp_q.delete();
            tag_q.delete();
        end else begin
            if (exp_q.size() > 0) begin
                void'(exp_q.pop_front());
                void'(tag_q.pop_front());
            end
            if (in_valid && rdy_n)
                push_frame(in_data, int'(len_code), int'(par_cfg), int'(stop_cfg),
                           msb_first, int'(half_div));
        end
    end

    always @(negedge clk) begin
        rdy_n = in_ready;
        if (!rst) begin
            bit    et;
            bit    er;
            string t;
            et = (exp_q.size() > 0) ? exp_q[0] : 1'b1;
            er = (exp_q.size() == 0);
            t  = (exp_q.size() > 0) ? tag_q[0] : "R1";
            n_vec++;
            if (txd !== et) begin
                n_bad++;
                $display("FAIL %s txd act=%b exp=%b t=%0t", t, txd, et, $time);
            end
            n_vec++;
            if (in_ready !== er) begin
                n_bad++;
                $display("FAIL R2 R10 in_ready act=%b exp=%b t=%0t", in_ready, er, $time);
            end
            n_vec++;
            if (busy !== !er) begin
                n_bad++;
                $display("FAIL R2 busy act=%b exp=%b t=%0t", busy, !er, $time);
            end
        end
    end

    // scramble: disturb all inputs right after acceptance (R9)
    // keep: leave in_valid high while busy (R10)
    task automatic send(input logic [7:0] dat, input int len, input int par, input int stp,
                        input bit msb, input int div, input bit scramble, input bit keep);
        @(negedge clk);
        in_data   = dat;
        len_code  = 2'(len);
        par_cfg   = 2'(par);
        stop_cfg  = 2'(stp);
        msb_first = msb;
        half_div  = DIV_W'(div);
        in_valid  = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        if (!keep) in_valid = 1'b0;
        if (scramble) begin
            in_data   = 8'($urandom);
            len_code  = 2'($urandom);
            par_cfg   = 2'($urandom);
            stop_cfg  = 2'($urandom);
            msb_first = 1'($urandom);
            half_div  = DIV_W'($urandom % 9);
        end
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        n_vec++;
        if (txd !== 1'b1 || in_ready !== 1'b1 || busy !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset act=%b%b%b exp=110", txd, in_ready, busy);
        end
        send(8'hA5, 3, 0, 0, 0, 2, 0, 0);   // R4 8 bits, no parity, one stop
        wait_idle();
        send(8'h13, 0, 1, 0, 1, 2, 0, 0);   // R5 R6 five bits MSB first, even
        wait_idle();
        send(8'h5C, 2, 2, 1, 0, 3, 0, 0);   // R6 R7 seven bits odd, 1.5 stop
        wait_idle();
        send(8'hFF, 1, 0, 2, 1, 1, 0, 0);   // R7 six bits, two stops
        wait_idle();
        send(8'h81, 3, 3, 3, 0, 0, 0, 0);   // R8 zero divisor, alias codes
        wait_idle();
        send(8'hE7, 0, 2, 1, 1, 3, 1, 0);   // R9 scrambled inputs mid frame
        wait_idle();
        send(8'h3C, 3, 1, 0, 0, 2, 1, 1);   // R10 valid held while busy
        send(8'hC3, 1, 2, 1, 1, 1, 0, 1);
        send(8'h0F, 2, 0, 2, 0, 2, 0, 0);
        wait_idle();
        for (int k = 0; k < 40; k++) begin
            send(8'($urandom), int'($urandom % 4), int'($urandom % 4), int'($urandom % 4),
                 1'($urandom), int'($urandom % 5), 1'($urandom), 1'($urandom));
        end
        in_valid = 1'b0;
        wait_idle();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule